// File: doc/BRIEF.md
# Immediate-Operand Accumulator Sequencer

This block is a very small processor built around one 8-bit accumulator. It reads instruction words from an external read-only program store and executes them strictly in address order. It has no jump path and no path for writing data back, so a given program always produces the same sequence of accumulator values. Every operand comes from a constant field inside the instruction word. The block never reads a data memory.

A surrounding design presents the program store as a combinational lookup. The block drives the address, and the store returns the word at that address on the data input within the same cycle. The accumulator is brought out on a port, so the result of each instruction can be seen there.

Each instruction takes two clock cycles. In the fetch cycle the word at the current address is latched into an instruction register. In the execute cycle the accumulator is updated and the address advances by one.

Top module: `imm_accum_cpu`

## Requirements
- R1: Reset is synchronous and active-low. Any rising edge that sees rst_n low clears the program counter and the accumulator to 0 and returns the sequencer to the fetch cycle, so rom_addr and acc_out read 0 afterwards and the next instruction starts with a fetch.
- R2: An instruction word is 11 bits wide, with opcode = bits [10:8] and constant = bits [7:0]. The word present on rom_data is captured only at the rising edge that ends the fetch cycle. The next rising edge ends the execute cycle.
- R3: Opcode 5 (load) sets the accumulator to the constant.
- R4: Opcode 2 sets the accumulator to its bitwise AND with the constant. Opcode 3 sets it to its bitwise OR with the constant.
- R5: Opcode 4 adds the constant to the accumulator modulo 256 and keeps no carry.
- R6: Opcode 1 replaces the accumulator with its bitwise complement and ignores the constant.
- R7: Opcodes 0, 6 and 7 leave the accumulator unchanged, whatever the constant is.
- R8: After every instruction, whatever its opcode, the program counter advances by exactly 1, and it wraps from 255 to 0.
- R9: acc_out and rom_addr do not change at the fetch edge. They change only at the execute edge.
- R10: The value on rom_data during the execute cycle has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| rom_addr | output | 8 | Program store address, equal to the program counter |
| rom_data | input | 11 | Instruction word read from the program store |
| acc_out | output | 8 | Current accumulator value |

## Verification
The program uses every opcode at least once, with operand values chosen so that each operation gives a result no other operation could give. The complement of 0xA5 differs from any masking result. An AND and an OR follow each other so that a swapped decode shows up. One addition crosses 255, which separates wrapping from saturation or a kept carry. The reserved and no-operation opcodes carry non-zero constants, so a load decoded by mistake would change the accumulator. A long run of increments drives the address past 255, which shows the wrap. In separate tests the data input is overridden during only one of the two cycles: an override in the execute cycle must have no effect, and an override in the fetch cycle must set the result. A reset applied mid-instruction must clear the state and restart with a fetch.

// File: rtl/iac_pkg.sv
// Shared definitions for the immediate-operand accumulator sequencer.
// Assumes an opcode field of fixed width at the top of each instruction word.
package iac_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OPC_NOP  = 3'd0,
        OPC_NOT  = 3'd1,
        OPC_AND  = 3'd2,
        OPC_OR   = 3'd3,
        OPC_ADD  = 3'd4,
        OPC_LOAD = 3'd5,
        OPC_RSV6 = 3'd6,
        OPC_RSV7 = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        FN_HOLD,
        FN_INV,
        FN_MASK,
        FN_MERGE,
        FN_SUM,
        FN_PASS
    } alu_fn_e;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef struct packed {
        alu_fn_e fn;
        logic    acc_we;
    } dec_t;

    // Maps an opcode to an ALU function and an accumulator write enable.
    function automatic dec_t decode_op(input opcode_e op);
        dec_t d;
        d.fn     = FN_HOLD;
        d.acc_we = 1'b0;
        case (op)
            OPC_NOT:  begin d.fn = FN_INV;   d.acc_we = 1'b1; end
            OPC_AND:  begin d.fn = FN_MASK;  d.acc_we = 1'b1; end
            OPC_OR:   begin d.fn = FN_MERGE; d.acc_we = 1'b1; end
            OPC_ADD:  begin d.fn = FN_SUM;   d.acc_we = 1'b1; end
            OPC_LOAD: begin d.fn = FN_PASS;  d.acc_we = 1'b1; end
            default:  begin d.fn = FN_HOLD;  d.acc_we = 1'b0; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/iac_ctrl.sv
// Control unit: a two-state phase sequencer, the instruction register and
// the opcode decoder. Assumes rom_data is valid throughout the fetch cycle.
module iac_ctrl #(
    parameter int DATA_W = 8,
    localparam int INSTR_W = iac_pkg::OP_W + DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [INSTR_W-1:0]    rom_data,
    output iac_pkg::phase_e       phase,
    output iac_pkg::opcode_e      opcode,
    output logic [DATA_W-1:0]     imm,
    output iac_pkg::alu_fn_e      alu_fn,
    output logic                  acc_we,
    output logic                  pc_inc
);
    import iac_pkg::*;

    phase_e              phase_q;
    logic [INSTR_W-1:0]  ir_q;
    dec_t                dec;

    // Alternate fetch and execute; restart in fetch on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_FETCH;
        else        phase_q <= (phase_q == PH_FETCH) ? PH_EXEC : PH_FETCH;
    end

    // Capture the instruction word only at the end of the fetch cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ir_q <= '0;
        else if (phase_q == PH_FETCH) ir_q <= rom_data;
    end

    // Split the instruction and decode it into datapath controls.
    always_comb begin
        opcode = opcode_e'(ir_q[INSTR_W-1 -: OP_W]);
        imm    = ir_q[DATA_W-1:0];
        dec    = decode_op(opcode);
        alu_fn = dec.fn;
        acc_we = dec.acc_we && (phase_q == PH_EXEC);
        pc_inc = (phase_q == PH_EXEC);
        phase  = phase_q;
    end

endmodule

// File: rtl/iac_pc.sv
// Program counter: steps by one when told to, wraps at its natural width.
module iac_pc #(
    parameter int PC_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc,
    output logic [PC_W-1:0] pc
);
    logic [PC_W-1:0] pc_q;

    // Clear on reset, otherwise advance by one when an instruction retires.
    always_ff @(posedge clk) begin
        if (!rst_n)   pc_q <= '0;
        else if (inc) pc_q <= pc_q + PC_W'(1);
    end

    assign pc = pc_q;

endmodule

// File: rtl/iac_alu.sv
// Combinational ALU: applies one function to the accumulator and a constant.
// The sum drops its carry-out.
module iac_alu #(
    parameter int DATA_W = 8
) (
    input  iac_pkg::alu_fn_e    fn,
    input  logic [DATA_W-1:0]   acc,
    input  logic [DATA_W-1:0]   imm,
    output logic [DATA_W-1:0]   result
);
    import iac_pkg::*;

    logic [DATA_W-1:0] bit_and;
    logic [DATA_W-1:0] bit_or;
    logic [DATA_W-1:0] bit_inv;

    // Bitwise lanes, one per accumulator bit.
    for (genvar b = 0; b < DATA_W; b++) begin : g_lane
        assign bit_and[b] = acc[b] & imm[b];
        assign bit_or[b]  = acc[b] | imm[b];
        assign bit_inv[b] = ~acc[b];
    end

    // Select the function result.
    always_comb begin
        case (fn)
            FN_INV:   result = bit_inv;
            FN_MASK:  result = bit_and;
            FN_MERGE: result = bit_or;
            FN_SUM:   result = acc + imm;
            FN_PASS:  result = imm;
            default:  result = acc;
        endcase
    end

endmodule

// File: rtl/imm_accum_cpu.sv
// Top of the accumulator sequencer. Runs the program store in address order,
// two cycles per instruction, with no jump and no write-back path.
// Assumes a program store that answers combinationally.
module imm_accum_cpu #(
    parameter int DATA_W = 8,
    parameter int PC_W   = 8,
    localparam int INSTR_W = iac_pkg::OP_W + DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PC_W-1:0]    rom_addr,
    input  logic [INSTR_W-1:0] rom_data,
    output logic [DATA_W-1:0]  acc_out
);
    import iac_pkg::*;

    phase_e            phase_w;
    opcode_e           op_w;
    logic [DATA_W-1:0] imm_w;
    alu_fn_e           fn_w;
    logic              acc_we_w;
    logic              pc_inc_w;
    logic [DATA_W-1:0] alu_res_w;
    logic [DATA_W-1:0] acc_q;

    iac_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rom_data (rom_data),
        .phase    (phase_w),
        .opcode   (op_w),
        .imm      (imm_w),
        .alu_fn   (fn_w),
        .acc_we   (acc_we_w),
        .pc_inc   (pc_inc_w)
    );

    iac_pc #(.PC_W(PC_W)) pc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (pc_inc_w),
        .pc    (rom_addr)
    );

    iac_alu #(.DATA_W(DATA_W)) alu_i (
        .fn     (fn_w),
        .acc    (acc_q),
        .imm    (imm_w),
        .result (alu_res_w)
    );

    // Accumulator: cleared on reset, loaded with the ALU result on execute.
    always_ff @(posedge clk) begin
        if (!rst_n)        acc_q <= '0;
        else if (acc_we_w) acc_q <= alu_res_w;
    end

    assign acc_out = acc_q;

endmodule

// File: rtl/iac_chk.sv
// Protocol checker for imm_accum_cpu, attached through bind.
module iac_chk #(
    parameter int DATA_W = 8,
    parameter int PC_W   = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [PC_W-1:0]      rom_addr,
    input logic [DATA_W-1:0]    acc_out,
    input iac_pkg::phase_e      phase,
    input iac_pkg::opcode_e     ir_op,
    input logic [DATA_W-1:0]    ir_imm
);
    import iac_pkg::*;

    logic was_rst_q = 1'b0;

    // Remember whether the previous edge saw reset asserted.
    always_ff @(posedge clk) was_rst_q <= !rst_n;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst_q |-> (rom_addr == '0 && acc_out == '0 && phase == PH_FETCH));

    // R2
    phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH) |=> (phase == PH_EXEC));

    // R9
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH) |=> ($stable(acc_out) && $stable(rom_addr)));

    // R8
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC) |=> (rom_addr == PC_W'($past(rom_addr) + PC_W'(1))));

    // R3
    load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && ir_op == OPC_LOAD) |=> (acc_out == $past(ir_imm)));

    // R5
    sum_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && ir_op == OPC_ADD)
        |=> (acc_out == DATA_W'($past(acc_out) + $past(ir_imm))));

    // R7
    idle_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && (ir_op == OPC_NOP || ir_op == OPC_RSV6 || ir_op == OPC_RSV7))
        |=> $stable(acc_out));

    // R6
    invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && ir_op == OPC_NOT) |=> (acc_out == ~$past(acc_out)));

endmodule

bind imm_accum_cpu iac_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rom_addr (rom_addr),
    .acc_out  (acc_out),
    .phase    (phase_w),
    .ir_op    (op_w),
    .ir_imm   (imm_w)
);

// File: tb/imm_accum_cpu_tb_top.sv
`timescale 1ns/1ps
module imm_accum_cpu_tb_top;

    localparam int NPROG = 16;

    // Entry: {opcode[2:0], constant[7:0], expected accumulator[7:0]}
    localparam logic [18:0] PROG [NPROG] = '{
        {3'd5, 8'hA5, 8'hA5},   // R3 load
        {3'd1, 8'h00, 8'h5A},   // R6 complement
        {3'd2, 8'h0F, 8'h0A},   // R4 and
        {3'd3, 8'h30, 8'h3A},   // R4 or
        {3'd4, 8'h10, 8'h4A},   // R5 add
        {3'd4, 8'hC0, 8'h0A},   // R5 add wraps
        {3'd0, 8'hFF, 8'h0A},   // R7 nop
        {3'd6, 8'h55, 8'h0A},   // R7 reserved 6
        {3'd7, 8'h77, 8'h0A},   // R7 reserved 7
        {3'd5, 8'hFF, 8'hFF},   // R3 load
        {3'd4, 8'h01, 8'h00},   // R5 add 255+1
        {3'd1, 8'h00, 8'hFF},   // R6 complement
        {3'd2, 8'h00, 8'h00},   // R4 and zero
        {3'd3, 8'h81, 8'h81},   // R4 or
        {3'd1, 8'h33, 8'h7E},   // R6 constant ignored
        {3'd5, 8'h00, 8'h00}    // R3 load zero
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rom_addr;
    logic [10:0] rom_data;
    logic [7:0]  acc_out;
    logic [10:0] rom [256];
    logic        ovr_en = 1'b0;
    logic [10:0] ovr_val = '0;
    int          checks = 0;
    int          errors = 0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    assign rom_data = ovr_en ? ovr_val : rom[rom_addr];

    imm_accum_cpu dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rom_addr (rom_addr),
        .rom_data (rom_data),
        .acc_out  (acc_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] prev;
        for (int a = 0; a < 256; a++)
            rom[a] = (a < NPROG) ? PROG[a][18:8] : {3'd4, 8'h01};

        // R1 reset state
        cyc(); cyc();
        chk("R1 addr after reset", rom_addr, 8'h00);
        chk("R1 acc after reset", acc_out, 8'h00);
        rst_n = 1'b1;

        // Table walk: R2..R9
        prev = 8'h00;
        for (int i = 0; i < NPROG; i++) begin
            cyc();
            chk("R9 acc held at fetch", acc_out, prev);
            chk("R9 addr held at fetch", rom_addr, 8'(i));
            cyc();
            chk("R2-table acc result", acc_out, PROG[i][7:0]);
            chk("R8 addr step", rom_addr, 8'(i + 1));
            prev = PROG[i][7:0];
        end

        // R8 wrap: 240 increments from address 16 to 255
        for (int k = 0; k < 240; k++) begin
            cyc(); cyc();
        end
        chk("R8 addr wrapped", rom_addr, 8'h00);
        chk("R5 increment run", acc_out, 8'hF0);
        cyc(); cyc();
        chk("R8 rerun after wrap", acc_out, 8'hA5);
        chk("R8 addr after wrap", rom_addr, 8'h01);

        // R10: override during execute of NOT at address 1
        cyc();
        ovr_en = 1'b1; ovr_val = {3'd5, 8'h3C};
        cyc();
        ovr_en = 1'b0;
        chk("R10 execute data ignored", acc_out, 8'h5A);
        chk("R10 addr", rom_addr, 8'h02);

        // R2: override during fetch of address 2 takes effect
        ovr_en = 1'b1; ovr_val = {3'd5, 8'h3C};
        cyc();
        ovr_en = 1'b0;
        cyc();
        chk("R2 fetch data captured", acc_out, 8'h3C);

        // R1: reset mid-instruction, after the fetch of address 3
        cyc();
        rst_n = 1'b0;
        cyc();
        chk("R1 mid-run addr cleared", rom_addr, 8'h00);
        chk("R1 mid-run acc cleared", acc_out, 8'h00);
        rst_n = 1'b1;
        cyc(); cyc();
        chk("R1 restart with fetch", acc_out, 8'hA5);
        chk("R1 restart addr", rom_addr, 8'h01);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule